// File: doc/BRIEF.md
# Mains-to-Seconds Cascaded Divider

This block converts a stream of single-cycle input ticks, one per mains cycle at 60 Hz, into a once-per-second output. All flops share one system clock. Each mains cycle is marked by a tick that is high for one clock cycle.

Two truncated binary up counters sit in series. The first counts modulo six, and its most significant bit gives a 10 Hz tap. The second counts modulo ten and steps only in the cycle in which the first stage wraps. Its most significant bit is a 1 Hz level with a one-fifth duty cycle. A single-cycle pulse marks each completed second.

Each stage finds its wrap by checking the incremented value before it is stored. So no value beyond a stage's last legal state is ever registered.

Top module: `mains_sec_divider`

## Requirements
- R1: An active-high `rst`, sampled on a rising clock edge, clears both counters and `sec_pulse_o` to zero. `rst` takes priority over a tick in the same cycle.
- R2: The low stage `lo_cnt_o` (3 bits, bit 0 least significant) moves one step per tick, through 0,1,2,3,4,5 and back to 0. The first tick after reset gives 1. Without a tick, it holds its value.
- R3: The high stage `hi_cnt_o` (4 bits, bit 0 least significant) moves one step only when a tick arrives while the low stage is at 5, through 0 to 9 and back to 0. Otherwise it holds its value.
- R4: The low stage never shows a value above 5, and the high stage never shows a value above 9, in any cycle.
- R5: `tap_o` equals bit 2 of the low stage. It is high in states 4 and 5, which is two of every six ticks.
- R6: `sec_level_o` equals bit 3 of the high stage. It is high in states 8 and 9, which is twelve of every sixty ticks.
- R7: `sec_pulse_o` is high for exactly one cycle: the cycle after the edge that sampled the tick which returned both stages to zero. That is once per sixty ticks.
- R8: Every counter change is visible in the cycle after the edge that sampled its tick. There is one register of latency from `tick_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_in | input | 1 | One-cycle marker of each mains cycle |
| lo_cnt_o | output | 3 | Modulo-6 stage value |
| hi_cnt_o | output | 4 | Modulo-10 stage value |
| tap_o | output | 1 | 10 Hz tap, one-third duty |
| sec_level_o | output | 1 | 1 Hz level, one-fifth duty |
| sec_pulse_o | output | 1 | Single-cycle pulse each second |

## Verification
A fault in the low stage shows up on `lo_cnt_o` and `tap_o` in the cycle after the tick that caused it. It also shifts every later carry into the high stage. A wrong carry or a wrong high-stage value appears on `hi_cnt_o` within six ticks, and the pulse then lands on the wrong tick within one sixty-tick period. The bench therefore compares every output in every cycle against a tick-count model, across dense, sparse and irregular tick patterns.

// File: rtl/mains_div_pkg.sv
package mains_div_pkg;
    localparam int unsigned LO_MOD_DEF = 6;
    localparam int unsigned HI_MOD_DEF = 10;

    typedef struct packed {
        logic pulse;
    } top_state_t;
endpackage

// File: rtl/trunc_stage.sv
module trunc_stage #(
    parameter int unsigned MOD = 6,
    parameter int unsigned W   = $clog2(MOD)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         adv_i,
    output logic [W-1:0] cnt_o,
    output logic         msb_o,
    output logic         carry_o
);
    localparam logic [W:0] LIMIT = (W+1)'(MOD);

    typedef struct packed {
        logic [W-1:0] cnt;
    } stage_t;

    stage_t     st_d;
    stage_t     st_q;
    logic [W:0] inc;
    logic       at_end;

    always_comb begin
        inc    = {1'b0, st_q.cnt} + 1'b1;
        at_end = (inc >= LIMIT);
        st_d   = st_q;
        if (adv_i) begin
            st_d.cnt = at_end ? '0 : inc[W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o   = st_q.cnt;
    assign msb_o   = st_q.cnt[W-1];
    assign carry_o = adv_i & at_end;
endmodule

// File: rtl/mains_sec_divider.sv
module mains_sec_divider
    import mains_div_pkg::*;
#(
    parameter int unsigned LO_MOD = LO_MOD_DEF,
    parameter int unsigned HI_MOD = HI_MOD_DEF,
    parameter int unsigned LO_W   = $clog2(LO_MOD),
    parameter int unsigned HI_W   = $clog2(HI_MOD)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            tick_in,
    output logic [LO_W-1:0] lo_cnt_o,
    output logic [HI_W-1:0] hi_cnt_o,
    output logic            tap_o,
    output logic            sec_level_o,
    output logic            sec_pulse_o
);
    logic       lo_carry;
    logic       hi_carry;
    top_state_t top_d;
    top_state_t top_q;

    trunc_stage #(.MOD(LO_MOD), .W(LO_W)) u_lo (
        .clk     (clk),
        .rst     (rst),
        .adv_i   (tick_in),
        .cnt_o   (lo_cnt_o),
        .msb_o   (tap_o),
        .carry_o (lo_carry)
    );

    trunc_stage #(.MOD(HI_MOD), .W(HI_W)) u_hi (
        .clk     (clk),
        .rst     (rst),
        .adv_i   (lo_carry),
        .cnt_o   (hi_cnt_o),
        .msb_o   (sec_level_o),
        .carry_o (hi_carry)
    );

    always_comb begin
        top_d       = top_q;
        top_d.pulse = hi_carry;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            top_q <= '0;
        end else begin
            top_q <= top_d;
        end
    end

    assign sec_pulse_o = top_q.pulse;
endmodule

// File: rtl/mains_sec_divider_chk.sv
module mains_sec_divider_chk #(
    parameter int unsigned LO_MOD = 6,
    parameter int unsigned HI_MOD = 10,
    parameter int unsigned LO_W   = 3,
    parameter int unsigned HI_W   = 4
) (
    input logic            clk,
    input logic            rst,
    input logic            tick_in,
    input logic [LO_W-1:0] lo_cnt_o,
    input logic [HI_W-1:0] hi_cnt_o,
    input logic            tap_o,
    input logic            sec_level_o,
    input logic            sec_pulse_o
);
    localparam logic [LO_W-1:0] LO_LAST = LO_W'(LO_MOD - 1);
    localparam logic [HI_W-1:0] HI_LAST = HI_W'(HI_MOD - 1);

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (lo_cnt_o == '0 && hi_cnt_o == '0 && !sec_pulse_o));

    p_lo_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !tick_in |=> $stable(lo_cnt_o));

    p_lo_wrap_r2: assert property (@(posedge clk) disable iff (rst)
        (tick_in && lo_cnt_o == LO_LAST) |=> lo_cnt_o == '0);

    p_hi_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !(tick_in && lo_cnt_o == LO_LAST) |=> $stable(hi_cnt_o));

    p_lo_range_r4: assert property (@(posedge clk) disable iff (rst)
        lo_cnt_o <= LO_LAST);

    p_hi_range_r4: assert property (@(posedge clk) disable iff (rst)
        hi_cnt_o <= HI_LAST);

    p_tap_r5: assert property (@(posedge clk) disable iff (rst)
        tap_o == lo_cnt_o[LO_W-1]);

    p_level_r6: assert property (@(posedge clk) disable iff (rst)
        sec_level_o == hi_cnt_o[HI_W-1]);

    p_pulse_zero_r7: assert property (@(posedge clk) disable iff (rst)
        sec_pulse_o |-> (lo_cnt_o == '0 && hi_cnt_o == '0));

    p_pulse_single_r7: assert property (@(posedge clk) disable iff (rst)
        sec_pulse_o |=> !sec_pulse_o);
endmodule

bind mains_sec_divider mains_sec_divider_chk #(
    .LO_MOD (LO_MOD),
    .HI_MOD (HI_MOD),
    .LO_W   (LO_W),
    .HI_W   (HI_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .tick_in     (tick_in),
    .lo_cnt_o    (lo_cnt_o),
    .hi_cnt_o    (hi_cnt_o),
    .tap_o       (tap_o),
    .sec_level_o (sec_level_o),
    .sec_pulse_o (sec_pulse_o)
);

// File: tb/mains_sec_divider_tb.sv
`timescale 1ns/1ps
module mains_sec_divider_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_in = 1'b0;
    logic [2:0] lo_cnt_o;
    logic [3:0] hi_cnt_o;
    logic       tap_o;
    logic       sec_level_o;
    logic       sec_pulse_o;

    int  n_chk = 0;
    int  n_fail = 0;
    int  ticks = 0;
    bit  pulse_e = 1'b0;
    bit  done = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    always #2 clk = ~clk;

    mains_sec_divider u_dut (
        .clk         (clk),
        .rst         (rst),
        .tick_in     (tick_in),
        .lo_cnt_o    (lo_cnt_o),
        .hi_cnt_o    (hi_cnt_o),
        .tap_o       (tap_o),
        .sec_level_o (sec_level_o),
        .sec_pulse_o (sec_pulse_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s at tick %0d: actual %0d expected %0d", req, ticks, act, exp);
        end
    endtask

    // Drive one cycle, update the model at the edge, compare at the falling edge.
    task automatic step(input bit r, input bit t);
        int lo_e;
        int hi_e;
        rst     = r;
        tick_in = t;
        @(posedge clk);
        if (r) begin
            ticks   = 0;
            pulse_e = 1'b0;
        end else begin
            if (t) ticks++;
            pulse_e = t && ticks > 0 && (ticks % 60) == 0;
        end
        @(negedge clk);
        lo_e = ticks % 6;
        hi_e = (ticks / 6) % 10;
        chk(r ? "R1 lo clear" : "R2/R8 lo stage", int'(lo_cnt_o), lo_e);
        chk(r ? "R1 hi clear" : "R3/R4 hi stage", int'(hi_cnt_o), hi_e);
        chk("R5 tap", int'(tap_o), int'(lo_e >= 4));
        chk("R6 second level", int'(sec_level_o), int'(hi_e >= 8));
        chk(r ? "R1 pulse clear" : "R7 second pulse", int'(sec_pulse_o), int'(pulse_e));
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog expired: actual 1 expected 0");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin : stim
        @(negedge clk);
        step(1'b1, 1'b0);
        step(1'b1, 1'b1);
        // R2: first tick after reset
        step(1'b0, 1'b1);
        chk("R2 first tick gives 1", int'(lo_cnt_o), 1);
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);
        // dense ticks: several full seconds
        for (int i = 0; i < 200; i++) step(1'b0, 1'b1);
        // sparse regular ticks
        for (int i = 0; i < 400; i++) step(1'b0, (i % 3) == 0);
        // irregular ticks
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(1'b0, lfsr[0]);
        end
        // R1: reset mid count with a tick present
        step(1'b1, 1'b1);
        chk("R1 reset beats tick", int'(lo_cnt_o), 0);
        for (int i = 0; i < 130; i++) step(1'b0, 1'b1);
        chk("R7 count at 130 ticks", int'(hi_cnt_o), 1);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule